// File: doc/BRIEF.md
# Mirrored Memory Map with Region-Wrapping Program Counter

This block serves a small processor core. It sorts an 18-bit address into one of three regions: writable RAM, read-only ROM, or the I/O port space. It serves data reads and writes through that decode. It also keeps the program counter and computes its successor for instruction fetch.

RAM and ROM hold 64 words each. Each region occupies an address window twice the boundary constant wide (the boundary constant is 63), and each window folds onto its 64 words by taking the address modulo 64. ROM words are loaded from parameters at reset. With the default parameters every ROM word is zero.

Port handshaking and instruction decode sit outside the block. The region code on `region` tells the port logic when an access belongs to it.

The program counter wraps within its own region. From the last RAM address it returns to address 0. From the last ROM address it returns to the first ROM address. It never moves while it points into I/O space.

Top module: `mirrored_mem_pc`

## Requirements
- R1: `region` reports 0 (RAM) for addresses below 126, 1 (ROM) for addresses 126 to 251, and 2 (I/O) for addresses of 252 and above.
- R2: In the RAM window the word touched is address modulo 64. For example, addresses 5 and 69 reach the same word, and address 100 reaches the word at address 36.
- R3: When `wr_en` is high and `addr` decodes to RAM, `wr_data` is stored on the rising clock edge. The combinational `rd_data` shows the stored value once that edge has passed.
- R4: A read in the ROM window returns the word at index address modulo 64. Word i holds ROM_BASE + i*ROM_STEP, truncated to 18 bits.
- R5: A write aimed at the ROM window leaves both ROM and RAM unchanged. On the following clock cycle, and for that one cycle only, `illegal_wr` is high.
- R6: A write in the I/O window changes no RAM word and raises no error. A read in the I/O window returns zero.
- R7: With the PC in the RAM window, an advance moves it to (PC+1) mod 126.
- R8: With the PC in the ROM window, an advance moves it to ((PC+1) mod 126) + 126, which keeps it inside the ROM window.
- R9: With the PC in the I/O window, an advance leaves it unchanged. `pc_next` equals `pc` there.
- R10: After reset the PC is 0, `illegal_wr` is 0, and every RAM word reads as 0.
- R11: `pc_load` takes priority over `pc_advance`. On a load, the PC takes `pc_load_addr` on the next edge.
- R12: `fetch_word` is the RAM or ROM word that the current PC selects through the same folding rule, and is 0 when the PC is in I/O space. `fetch_region` holds the PC's region code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 18 | Data access address |
| wr_en | input | 1 | Write strobe for the data access |
| wr_data | input | 18 | Data to write |
| rd_data | output | 18 | Combinational read data for `addr` |
| region | output | 2 | Region code of `addr` (0 RAM, 1 ROM, 2 I/O) |
| illegal_wr | output | 1 | One-cycle pulse after a write aimed at ROM |
| pc_advance | input | 1 | Step the PC to its successor |
| pc_load | input | 1 | Load the PC from `pc_load_addr` |
| pc_load_addr | input | 18 | New PC value |
| pc | output | 18 | Current program counter |
| pc_next | output | 18 | Successor of the current PC |
| fetch_region | output | 2 | Region code of the PC |
| fetch_word | output | 18 | Word selected by the PC |

## Verification
The following properties are checked on every cycle:
- after an advance, the PC stays inside its RAM or ROM window and never moves while in I/O space;
- a load always wins over an advance;
- a RAM write lands in the word it addressed;
- ROM words never change after reset;
- an error pulse appears only after a write aimed at ROM, and I/O reads return zero.

Only the bench scenarios can show the exact aliasing of specific addresses and the wrap points at 125 and 251. They also show the ROM contents given by the initial parameters, and that a write rejected at ROM leaves the RAM word with the same index untouched.

// File: rtl/mm_pkg.sv
package mm_pkg;

  typedef enum logic [1:0] {
    REG_RAM = 2'd0,
    REG_ROM = 2'd1,
    REG_IO  = 2'd2
  } region_e;

  // Region of an address, given the boundary constant.
  function automatic region_e mm_region(input int unsigned a, input int unsigned bound);
    if (a < 2 * bound)      return REG_RAM;
    else if (a < 4 * bound) return REG_ROM;
    else                    return REG_IO;
  endfunction

  // Physical word index inside a folded window.
  function automatic int unsigned mm_index(input int unsigned a, input int unsigned depth);
    return a % depth;
  endfunction

  // Successor of a program counter; wraps within its own region.
  function automatic int unsigned mm_pc_step(input int unsigned pc, input int unsigned bound);
    int unsigned span;
    span = 2 * bound;
    if (pc < span)          return (pc + 1) % span;
    else if (pc < 2 * span) return ((pc + 1) % span) + span;
    else                    return pc;
  endfunction

endpackage

// File: rtl/mm_region_decode.sv
module mm_region_decode
  import mm_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DEPTH  = 64,
  parameter int BOUND  = 63,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [IDX_W-1:0]  index
);

  logic [31:0] addr_wide;

  assign addr_wide = {{(32-ADDR_W){1'b0}}, addr};
  assign region    = mm_region(addr_wide, BOUND);
  assign index     = IDX_W'(mm_index(addr_wide, DEPTH));

endmodule

// File: rtl/mm_ram.sv
module mm_ram #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [IDX_W-1:0]  rd_idx_b,
  output logic [DATA_W-1:0] rd_data_b
);

  logic [DATA_W-1:0] cell_q [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
    logic hit;
    assign hit = we && (wr_idx == IDX_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cell_q[gi] <= '0;
      else if (hit) cell_q[gi] <= wr_data;
    end
  end

  assign rd_data_a = cell_q[rd_idx_a];
  assign rd_data_b = cell_q[rd_idx_b];

  AST_RAM_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> cell_q[$past(wr_idx)] == $past(wr_data)); // R3

  AST_RAM_HOLDS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> cell_q[$past(rd_idx_a)] == $past(rd_data_a)); // R5

endmodule

// File: rtl/mm_rom.sv
module mm_rom #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 64,
  parameter logic [DATA_W-1:0] ROM_BASE = '0,
  parameter logic [DATA_W-1:0] ROM_STEP = '0,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [IDX_W-1:0]  rd_idx_b,
  output logic [DATA_W-1:0] rd_data_b
);

  logic [DATA_W-1:0] word_q [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    localparam logic [DATA_W-1:0] INIT = ROM_BASE + DATA_W'(gi) * ROM_STEP;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q[gi] <= INIT;
    end

    AST_ROM_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      ##1 $stable(word_q[gi])); // R5
  end

  assign rd_data_a = word_q[rd_idx_a];
  assign rd_data_b = word_q[rd_idx_b];

endmodule

// File: rtl/mm_pc_unit.sv
module mm_pc_unit
  import mm_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BOUND  = 63,
  localparam int RAM_LIM = 2 * BOUND,
  localparam int ROM_LIM = 4 * BOUND
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] pc_next
);

  logic [ADDR_W-1:0] pc_q;
  logic [31:0]       pc_wide;
  logic              in_ram, in_rom, in_io;
  logic              step_evt;

  assign pc_wide  = {{(32-ADDR_W){1'b0}}, pc_q};
  assign pc_next  = ADDR_W'(mm_pc_step(pc_wide, BOUND));
  assign in_ram   = pc_wide < RAM_LIM;
  assign in_rom   = !in_ram && (pc_wide < ROM_LIM);
  assign in_io    = !in_ram && !in_rom;
  assign step_evt = advance && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pc_q <= '0;
    else if (load)     pc_q <= load_addr;
    else if (advance)  pc_q <= pc_next;
  end

  assign pc = pc_q;

  AST_PC_RAM_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt && in_ram |=> in_ram); // R7

  AST_PC_RAM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt && (pc_wide < RAM_LIM - 1) |=> pc_q == $past(pc_q) + 1'b1); // R7

  AST_PC_ROM_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt && in_rom |=> in_rom); // R8

  AST_PC_IO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt && in_io |=> $stable(pc_q)); // R9

  AST_PC_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pc_q == $past(load_addr)); // R11

endmodule

// File: rtl/mirrored_mem_pc.sv
module mirrored_mem_pc
  import mm_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 18,
  parameter int DEPTH  = 64,
  parameter int BOUND  = 63,
  parameter logic [DATA_W-1:0] ROM_BASE = '0,
  parameter logic [DATA_W-1:0] ROM_STEP = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        region,
  output logic              illegal_wr,
  input  logic              pc_advance,
  input  logic              pc_load,
  input  logic [ADDR_W-1:0] pc_load_addr,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] pc_next,
  output logic [1:0]        fetch_region,
  output logic [DATA_W-1:0] fetch_word
);

  localparam int IDX_W = $clog2(DEPTH);

  region_e           data_reg, pc_reg;
  logic [IDX_W-1:0]  data_idx, pc_idx;
  logic [DATA_W-1:0] ram_data, ram_fetch, rom_data, rom_fetch;
  logic              ram_wr_strobe, rom_wr_attempt, illegal_q;

  mm_region_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .BOUND(BOUND)) u_data_dec (
    .addr(addr), .region(data_reg), .index(data_idx)
  );

  mm_region_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .BOUND(BOUND)) u_pc_dec (
    .addr(pc), .region(pc_reg), .index(pc_idx)
  );

  assign ram_wr_strobe  = wr_en && (data_reg == REG_RAM);
  assign rom_wr_attempt = wr_en && (data_reg == REG_ROM);

  mm_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .we(ram_wr_strobe), .wr_idx(data_idx), .wr_data(wr_data),
    .rd_idx_a(data_idx), .rd_data_a(ram_data),
    .rd_idx_b(pc_idx),   .rd_data_b(ram_fetch)
  );

  mm_rom #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ROM_BASE(ROM_BASE), .ROM_STEP(ROM_STEP)) u_rom (
    .clk(clk), .rst_n(rst_n),
    .rd_idx_a(data_idx), .rd_data_a(rom_data),
    .rd_idx_b(pc_idx),   .rd_data_b(rom_fetch)
  );

  mm_pc_unit #(.ADDR_W(ADDR_W), .BOUND(BOUND)) u_pc (
    .clk(clk), .rst_n(rst_n),
    .advance(pc_advance), .load(pc_load), .load_addr(pc_load_addr),
    .pc(pc), .pc_next(pc_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) illegal_q <= 1'b0;
    else        illegal_q <= rom_wr_attempt;
  end

  always_comb begin
    unique case (data_reg)
      REG_RAM: rd_data = ram_data;
      REG_ROM: rd_data = rom_data;
      default: rd_data = '0;
    endcase
  end

  always_comb begin
    unique case (pc_reg)
      REG_RAM: fetch_word = ram_fetch;
      REG_ROM: fetch_word = rom_fetch;
      default: fetch_word = '0;
    endcase
  end

  assign region       = data_reg;
  assign fetch_region = pc_reg;
  assign illegal_wr   = illegal_q;

  AST_ERR_ONLY_AFTER_ROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_wr |-> $past(wr_en) && ($past(region) == 2'd1)); // R5

  AST_NO_ERR_OUTSIDE_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (region != 2'd1) |=> !illegal_wr); // R6

  AST_IO_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (region == 2'd2) |-> rd_data == '0); // R6

  AST_IO_FETCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_region == 2'd2) |-> fetch_word == '0); // R12

endmodule

// File: tb/sim_mirrored_mem_pc.sv
`timescale 1ns/1ps
module sim_mirrored_mem_pc;

  localparam logic [17:0] RBASE = 18'h01000;
  localparam logic [17:0] RSTEP = 18'h00011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] addr = '0, wr_data = '0, pc_load_addr = '0;
  logic        wr_en = 1'b0, pc_advance = 1'b0, pc_load = 1'b0;
  logic [17:0] rd_data, pc, pc_next, fetch_word;
  logic [1:0]  region, fetch_region;
  logic        illegal_wr;

  always #4 clk = ~clk;

  mirrored_mem_pc #(.ROM_BASE(RBASE), .ROM_STEP(RSTEP)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .region(region), .illegal_wr(illegal_wr),
    .pc_advance(pc_advance), .pc_load(pc_load), .pc_load_addr(pc_load_addr),
    .pc(pc), .pc_next(pc_next), .fetch_region(fetch_region), .fetch_word(fetch_word)
  );

  typedef enum int {OBS_RD, OBS_REGION, OBS_ILL, OBS_PC, OBS_PCN, OBS_FREG, OBS_FWORD} obs_e;
  typedef struct {
    string       tag;
    obs_e        sel;
    logic [17:0] exp;
  } item_t;

  item_t       sb[$];
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;
  logic [17:0] ram_m [64];

  function automatic logic [17:0] rom_m(input int a);
    return RBASE + 18'(a % 64) * RSTEP;
  endfunction

  function automatic logic [17:0] succ_m(input logic [17:0] p);
    if (p <= 18'd125)      return (p == 18'd125) ? 18'd0 : p + 1;
    else if (p <= 18'd251) return (p == 18'd251) ? 18'd126 : p + 1;
    else                   return p;
  endfunction

  task automatic expect_val(input string tag, input obs_e sel, input logic [17:0] v);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = v;
    sb.push_back(it);
  endtask

  task automatic drive(input logic [17:0] a, input logic we, input logic [17:0] wd,
                       input logic adv, input logic ld, input logic [17:0] la);
    @(negedge clk);
    #1;
    addr = a; wr_en = we; wr_data = wd;
    pc_advance = adv; pc_load = ld; pc_load_addr = la;
    if (we && a < 18'd126) ram_m[a % 64] = wd;
  endtask

  task automatic idle(input logic [17:0] a);
    drive(a, 1'b0, '0, 1'b0, 1'b0, '0);
  endtask

  // Monitor: compare the queued expectations one clock edge after they were pushed.
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        item_t it;
        logic [17:0] act;
        it = sb.pop_front();
        case (it.sel)
          OBS_RD:     act = rd_data;
          OBS_REGION: act = {16'd0, region};
          OBS_ILL:    act = {17'd0, illegal_wr};
          OBS_PC:     act = pc;
          OBS_PCN:    act = pc_next;
          OBS_FREG:   act = {16'd0, fetch_region};
          default:    act = fetch_word;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [17:0] pm;
    for (int k = 0; k < 64; k++) ram_m[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    idle(18'd0);
    expect_val("R10", OBS_PC, 18'd0);
    expect_val("R10", OBS_ILL, 18'd0);
    expect_val("R10", OBS_RD, 18'd0);
    idle(18'd70);
    expect_val("R10", OBS_RD, 18'd0);

    // R1: region decode at the boundaries
    idle(18'd125);     expect_val("R1", OBS_REGION, 18'd0);
    idle(18'd126);     expect_val("R1", OBS_REGION, 18'd1);
    idle(18'd251);     expect_val("R1", OBS_REGION, 18'd1);
    idle(18'd252);     expect_val("R1", OBS_REGION, 18'd2);
    idle(18'h3FFFF);   expect_val("R1", OBS_REGION, 18'd2);

    // R3, R2: synchronous RAM write and aliasing
    drive(18'd5, 1'b1, 18'h12345, 1'b0, 1'b0, '0);
    expect_val("R3", OBS_RD, ram_m[5]);
    idle(18'd69);   expect_val("R2", OBS_RD, 18'h12345);
    drive(18'd100, 1'b1, 18'h2AAAA, 1'b0, 1'b0, '0);
    expect_val("R3", OBS_RD, 18'h2AAAA);
    idle(18'd36);   expect_val("R2", OBS_RD, 18'h2AAAA);

    // R4: ROM contents with folding
    idle(18'd126);  expect_val("R4", OBS_RD, rom_m(126));
    idle(18'd200);  expect_val("R4", OBS_RD, rom_m(200));
    idle(18'd251);  expect_val("R4", OBS_RD, rom_m(251));

    // R5: rejected ROM write
    drive(18'd130, 1'b1, 18'h3FFFF, 1'b0, 1'b0, '0);
    expect_val("R5", OBS_ILL, 18'd1);
    expect_val("R5", OBS_RD, rom_m(130));
    idle(18'd2);
    expect_val("R5", OBS_ILL, 18'd0);
    expect_val("R5", OBS_RD, ram_m[2]);

    // R6: write into I/O space
    drive(18'd300, 1'b1, 18'h11111, 1'b0, 1'b0, '0);
    expect_val("R6", OBS_ILL, 18'd0);
    expect_val("R6", OBS_RD, 18'd0);
    idle(18'd44);
    expect_val("R6", OBS_RD, 18'd0);

    // R7: PC stepping and wrap in RAM
    pm = 18'd0;
    for (int k = 0; k < 3; k++) begin
      drive(18'd0, 1'b0, '0, 1'b1, 1'b0, '0);
      pm = succ_m(pm);
      expect_val("R7", OBS_PC, pm);
    end
    drive(18'd0, 1'b0, '0, 1'b0, 1'b1, 18'd124);
    expect_val("R11", OBS_PC, 18'd124);
    drive(18'd0, 1'b0, '0, 1'b1, 1'b0, '0);
    expect_val("R7", OBS_PC, 18'd125);
    expect_val("R7", OBS_PCN, 18'd0);
    drive(18'd0, 1'b0, '0, 1'b1, 1'b0, '0);
    expect_val("R7", OBS_PC, 18'd0);

    // R8: PC stepping and wrap in ROM
    drive(18'd0, 1'b0, '0, 1'b0, 1'b1, 18'd250);
    expect_val("R8", OBS_PC, 18'd250);
    drive(18'd0, 1'b0, '0, 1'b1, 1'b0, '0);
    expect_val("R8", OBS_PC, succ_m(18'd250));
    drive(18'd0, 1'b0, '0, 1'b1, 1'b0, '0);
    expect_val("R8", OBS_PC, 18'd126);
    drive(18'd0, 1'b0, '0, 1'b1, 1'b0, '0);
    expect_val("R8", OBS_PC, 18'd127);

    // R9: PC frozen in I/O space
    drive(18'd0, 1'b0, '0, 1'b0, 1'b1, 18'd252);
    expect_val("R9", OBS_PCN, 18'd252);
    drive(18'd0, 1'b0, '0, 1'b1, 1'b0, '0);
    expect_val("R9", OBS_PC, 18'd252);
    drive(18'd0, 1'b0, '0, 1'b0, 1'b1, 18'h3FFFF);
    drive(18'd0, 1'b0, '0, 1'b1, 1'b0, '0);
    expect_val("R9", OBS_PC, 18'h3FFFF);

    // R11: load beats advance
    drive(18'd0, 1'b0, '0, 1'b1, 1'b1, 18'd10);
    expect_val("R11", OBS_PC, 18'd10);

    // R12: instruction fetch through the PC
    drive(18'd0, 1'b0, '0, 1'b0, 1'b1, 18'd5);
    expect_val("R12", OBS_FWORD, ram_m[5]);
    expect_val("R12", OBS_FREG, 18'd0);
    drive(18'd0, 1'b0, '0, 1'b0, 1'b1, 18'd69);
    expect_val("R12", OBS_FWORD, 18'h12345);
    drive(18'd0, 1'b0, '0, 1'b0, 1'b1, 18'd200);
    expect_val("R12", OBS_FWORD, rom_m(200));
    expect_val("R12", OBS_FREG, 18'd1);
    drive(18'd0, 1'b0, '0, 1'b0, 1'b1, 18'd260);
    expect_val("R12", OBS_FWORD, 18'd0);
    expect_val("R12", OBS_FREG, 18'd2);

    idle(18'd0);
    @(negedge clk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule